// File: doc/BRIEF.md
# Stop Mode Recovery Controller

This block puts a small microcontroller into its lowest-power stop condition and brings it back out safely. It runs on the fast oscillator clock. When the CPU raises a stop request, the block drops the enables for the CPU and peripheral clocks. It can keep the fast clock alive for a wake-up timer, or let it stop. While stopped, its recovery counter is held at zero. The block then waits for a wake event.

A module interrupt or a debug break starts a timed recovery. A long, crystal-safe delay or a short delay is chosen by a configuration bit, and that bit is captured when recovery starts. Only when the full delay has passed does the block restore the clocks and strobe the CPU that it may begin interrupt stacking. A reset wake skips the delay and returns the block straight to normal running.

The three states are RUN, STOPPED and RECOVER. The transitions are:
- ENTER: RUN to STOPPED, on a stop request.
- WAKE: STOPPED to RECOVER, on an interrupt or a break.
- HARD_EXIT: STOPPED or RECOVER to RUN, on a reset wake.
- DONE: RECOVER to RUN, when the delay expires.

Top module: `stop_recovery_ctrl`

## Requirements
- R1: After rst_n is asserted low, the block is in RUN with cpu_clk_en=1, fast_clk_en=1, cpu_stopped=0 and rec_done=0.
- R2: A stop_req sampled high at a clock edge while in RUN makes cpu_clk_en=0 and cpu_stopped=1 from the cycle following that edge.
- R3: fast_clk_en is 1 in RUN and in RECOVER. In STOPPED it equals the value of cfg_osc_keep sampled at the edge that accepted the stop request.
- R4: In STOPPED the block stays stopped until a wake event arrives, and stop_req has no effect outside RUN. The recovery counter reads zero in every state other than RECOVER.
- R5: If wake_irq or wake_brk is sampled at edge k in STOPPED, then rec_done and cpu_clk_en become 1 after edge k+N, where N is LONG_CYCLES when the select bit is 0 and SHORT_CYCLES when the select bit is 1.
- R6: rec_done is high for exactly one cycle, in the same cycle that cpu_clk_en rises and cpu_stopped falls.
- R7: wake_rst sampled in STOPPED or in RECOVER returns the block to RUN after that edge with rec_done kept at 0. It takes priority over wake_irq and wake_brk.
- R8: cfg_short_rec is sampled only at the edge that starts recovery. Changing it during recovery does not change that recovery's length.
- R9: wake_irq and wake_brk that arrive during RECOVER do not change the recovery length.
- R10: wake_irq, wake_brk and wake_rst that arrive in RUN leave cpu_clk_en=1 and cpu_stopped=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stop_req | input | 1 | CPU request to enter stop |
| wake_irq | input | 1 | Module interrupt wake request |
| wake_brk | input | 1 | Debug break wake request |
| wake_rst | input | 1 | Reset wake request; skips the delay |
| cfg_short_rec | input | 1 | 1 selects the short recovery delay |
| cfg_osc_keep | input | 1 | 1 keeps the fast clock running in stop |
| cpu_clk_en | output | 1 | Enable for the CPU and peripheral clocks |
| fast_clk_en | output | 1 | Enable for the fast clock |
| cpu_stopped | output | 1 | CPU is held in stop or recovery |
| rec_done | output | 1 | One-cycle strobe; the CPU may start stacking |

## Verification
The bench builds the block with LONG_CYCLES=48 and SHORT_CYCLES=5, not the default 4096 and 32. With these values, many complete recoveries of both lengths fit in one short run. The small values also make it cheap to reach the corner cases: a select bit flipped during recovery, wake pulses during recovery, and reset wakes in both stopped states. The recovery length is counted in clock cycles at the ports for each of these cases.

// File: rtl/stoprec_pkg.sv
package stoprec_pkg;
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STOPPED = 2'd1,
        ST_RECOVER = 2'd2
    } stop_state_e;
endpackage

// File: rtl/stoprec_timer.sv
module stoprec_timer #(
    parameter int LONG_CYCLES  = 4096,
    parameter int SHORT_CYCLES = 32,
    localparam int CNT_W       = $clog2(LONG_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             count_en,
    input  logic             short_sel,
    output logic             expired,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYCLES - 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYCLES - 1);

    logic             sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;

    // delay select is captured once, when recovery starts
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sel_q <= 1'b0;
        else if (start) sel_q <= short_sel;
    end

    assign last    = sel_q ? SHORT_LAST : LONG_LAST;
    assign expired = (cnt_q == last);

    // counter is held at zero whenever it is not timing a recovery
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (count_en && !expired) cnt_q <= cnt_q + 1'b1;
        else                           cnt_q <= '0;
    end

    assign count = cnt_q;

    a_r5_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LONG_LAST);
    a_r8_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        count_en |=> $stable(sel_q));
endmodule

// File: rtl/stoprec_fsm.sv
module stoprec_fsm
    import stoprec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        stop_req,
    input  logic        wake_irq,
    input  logic        wake_brk,
    input  logic        wake_rst,
    input  logic        cfg_osc_keep,
    input  logic        timer_expired,
    output stop_state_e state_q,
    output logic        start,
    output logic        count_en,
    output logic        cpu_clk_en,
    output logic        fast_clk_en,
    output logic        cpu_stopped,
    output logic        rec_done
);
    stop_state_e nxt;
    logic        keep_q;
    logic        accept;
    logic        keep_nxt;

    assign accept   = (state_q == ST_RUN) && stop_req;
    assign keep_nxt = accept ? cfg_osc_keep : keep_q;
    assign start    = (state_q == ST_STOPPED) && !wake_rst && (wake_irq || wake_brk);
    assign count_en = (state_q == ST_RECOVER) && !wake_rst;

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_RUN:     if (stop_req) nxt = ST_STOPPED;
            ST_STOPPED: begin
                if (wake_rst)                  nxt = ST_RUN;
                else if (wake_irq || wake_brk) nxt = ST_RECOVER;
            end
            ST_RECOVER: if (wake_rst || timer_expired) nxt = ST_RUN;
            default:    nxt = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            keep_q  <= 1'b0;
        end else begin
            state_q <= nxt;
            keep_q  <= keep_nxt;
        end
    end

    // registered outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_clk_en  <= 1'b1;
            fast_clk_en <= 1'b1;
            cpu_stopped <= 1'b0;
            rec_done    <= 1'b0;
        end else begin
            cpu_clk_en  <= (nxt == ST_RUN);
            cpu_stopped <= (nxt != ST_RUN);
            fast_clk_en <= (nxt == ST_STOPPED) ? keep_nxt : 1'b1;
            rec_done    <= (state_q == ST_RECOVER) && !wake_rst && timer_expired;
        end
    end

    a_r2_stop_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && stop_req) |=> (!cpu_clk_en && cpu_stopped));
    a_r3_fast_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER) |-> fast_clk_en);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |=> !rec_done);
    a_r6_done_restores: assert property (@(posedge clk) disable iff (!rst_n)
        rec_done |-> (cpu_clk_en && !cpu_stopped));
    a_r7_reset_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && wake_rst) |=> (cpu_clk_en && !rec_done));
    a_r9_wake_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && !wake_rst && !timer_expired) |=> (state_q == ST_RECOVER));
endmodule

// File: rtl/stop_recovery_ctrl.sv
module stop_recovery_ctrl
    import stoprec_pkg::*;
#(
    parameter int LONG_CYCLES  = 4096,
    parameter int SHORT_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic wake_irq,
    input  logic wake_brk,
    input  logic wake_rst,
    input  logic cfg_short_rec,
    input  logic cfg_osc_keep,
    output logic cpu_clk_en,
    output logic fast_clk_en,
    output logic cpu_stopped,
    output logic rec_done
);
    localparam int CNT_W = $clog2(LONG_CYCLES + 1);

    stop_state_e      state;
    logic             start;
    logic             count_en;
    logic             expired;
    logic [CNT_W-1:0] count;

    stoprec_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_req      (stop_req),
        .wake_irq      (wake_irq),
        .wake_brk      (wake_brk),
        .wake_rst      (wake_rst),
        .cfg_osc_keep  (cfg_osc_keep),
        .timer_expired (expired),
        .state_q       (state),
        .start         (start),
        .count_en      (count_en),
        .cpu_clk_en    (cpu_clk_en),
        .fast_clk_en   (fast_clk_en),
        .cpu_stopped   (cpu_stopped),
        .rec_done      (rec_done)
    );

    stoprec_timer #(
        .LONG_CYCLES  (LONG_CYCLES),
        .SHORT_CYCLES (SHORT_CYCLES)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .count_en  (count_en),
        .short_sel (cfg_short_rec),
        .expired   (expired),
        .count     (count)
    );

    a_r4_counter_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RECOVER) |-> (count == '0));
endmodule

// File: tb/tb_stop_recovery_ctrl.sv
module tb_stop_recovery_ctrl;
    localparam int LONG_N  = 48;
    localparam int SHORT_N = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0, wake_irq = 1'b0, wake_brk = 1'b0, wake_rst = 1'b0;
    logic cfg_short_rec = 1'b0, cfg_osc_keep = 1'b0;
    logic cpu_clk_en, fast_clk_en, cpu_stopped, rec_done;

    int total = 0;
    int fails = 0;

    stop_recovery_ctrl #(.LONG_CYCLES(LONG_N), .SHORT_CYCLES(SHORT_N)) dut (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wake_irq(wake_irq),
        .wake_brk(wake_brk), .wake_rst(wake_rst), .cfg_short_rec(cfg_short_rec),
        .cfg_osc_keep(cfg_osc_keep), .cpu_clk_en(cpu_clk_en),
        .fast_clk_en(fast_clk_en), .cpu_stopped(cpu_stopped), .rec_done(rec_done)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // behavioural model: 0 running, 1 stopped, 2 recovering
    int  m_st = 0;
    int  m_left = 0;
    bit  m_keep = 0;
    bit  m_done = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_left = 0; m_keep = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_st == 0) begin
                if (stop_req) begin m_st = 1; m_keep = cfg_osc_keep; end
            end else if (m_st == 1) begin
                if (wake_rst) m_st = 0;
                else if (wake_irq || wake_brk) begin
                    m_st = 2;
                    m_left = cfg_short_rec ? SHORT_N : LONG_N;
                end
            end else begin
                if (wake_rst) m_st = 0;
                else begin
                    m_left--;
                    if (m_left == 0) begin m_st = 0; m_done = 1; end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 R6 R7", "cpu_clk_en", int'(cpu_clk_en), int'(m_st == 0));
            chk("R3", "fast_clk_en", int'(fast_clk_en), (m_st == 1) ? int'(m_keep) : 1);
            chk("R2 R4", "cpu_stopped", int'(cpu_stopped), int'(m_st != 0));
            chk("R5 R6", "rec_done", int'(rec_done), int'(m_done));
        end
    end

    task automatic enter_stop(input logic keep);
        @(negedge clk);
        cfg_osc_keep = keep;
        stop_req = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic recover(input logic sel, input logic via_brk, input int flip_at,
                           input int poke_at, output int n);
        cfg_short_rec = sel;
        if (via_brk) wake_brk = 1'b1; else wake_irq = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 1) begin wake_irq = 1'b0; wake_brk = 1'b0; end
            if (n == flip_at) cfg_short_rec = ~cfg_short_rec;
            if (n == poke_at) begin wake_irq = 1'b1; wake_brk = 1'b1; end
            if (n == poke_at + 1) begin wake_irq = 1'b0; wake_brk = 1'b0; end
        end while (!rec_done && n < 200);
        n = n - 1;
        cfg_short_rec = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1", "cpu_clk_en in reset", int'(cpu_clk_en), 1);
        chk("R1", "rec_done in reset", int'(rec_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "cpu_stopped after reset", int'(cpu_stopped), 0);
        chk("R1", "fast_clk_en after reset", int'(fast_clk_en), 1);

        // R10: wake sources while running
        wake_irq = 1'b1; wake_brk = 1'b1; wake_rst = 1'b1;
        repeat (3) @(negedge clk);
        wake_irq = 1'b0; wake_brk = 1'b0; wake_rst = 1'b0;
        @(negedge clk);
        chk("R10", "cpu_stopped after RUN wakes", int'(cpu_stopped), 0);
        chk("R10", "cpu_clk_en after RUN wakes", int'(cpu_clk_en), 1);

        // long recovery, fast clock off in stop
        enter_stop(1'b0);
        chk("R2", "cpu_clk_en in stop", int'(cpu_clk_en), 0);
        chk("R3", "fast_clk_en stop keep=0", int'(fast_clk_en), 0);
        stop_req = 1'b1;
        repeat (4) @(negedge clk);
        stop_req = 1'b0;
        chk("R4", "still stopped without wake", int'(cpu_stopped), 1);
        recover(1'b0, 1'b0, -1, -10, n);
        chk("R5", "long recovery cycles", n, LONG_N);

        // short recovery via break, fast clock kept
        enter_stop(1'b1);
        chk("R3", "fast_clk_en stop keep=1", int'(fast_clk_en), 1);
        recover(1'b1, 1'b1, -1, -10, n);
        chk("R5", "short recovery cycles", n, SHORT_N);

        // R8: select changed mid-recovery
        enter_stop(1'b0);
        recover(1'b1, 1'b0, 2, -10, n);
        chk("R8", "short kept after flip", n, SHORT_N);
        enter_stop(1'b0);
        recover(1'b0, 1'b1, 3, -10, n);
        chk("R8", "long kept after flip", n, LONG_N);

        // R9: wake pulses during recovery
        enter_stop(1'b1);
        recover(1'b0, 1'b0, -1, 10, n);
        chk("R9", "long recovery with wake pulse", n, LONG_N);
        enter_stop(1'b0);
        recover(1'b1, 1'b1, -1, 3, n);
        chk("R9", "short recovery with wake pulse", n, SHORT_N);

        // R7: reset wake from STOPPED, together with an interrupt
        enter_stop(1'b0);
        wake_rst = 1'b1; wake_irq = 1'b1;
        @(negedge clk);
        wake_rst = 1'b0; wake_irq = 1'b0;
        chk("R7", "cpu_clk_en after reset wake", int'(cpu_clk_en), 1);
        chk("R7", "rec_done after reset wake", int'(rec_done), 0);

        // R7: reset wake during RECOVER
        enter_stop(1'b1);
        wake_irq = 1'b1;
        @(negedge clk);
        wake_irq = 1'b0;
        repeat (4) @(negedge clk);
        wake_rst = 1'b1;
        @(negedge clk);
        wake_rst = 1'b0;
        chk("R7", "running after abort", int'(cpu_stopped), 0);
        chk("R7", "no strobe on abort", int'(rec_done), 0);
        repeat (LONG_N + 2) @(negedge clk);
        chk("R7", "no late strobe", int'(rec_done), 0);

        // R4: a fresh recovery after the abort starts from zero
        enter_stop(1'b0);
        recover(1'b1, 1'b0, -1, -10, n);
        chk("R4", "short recovery after abort", n, SHORT_N);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule